// File: doc/BRIEF.md
# SMBus Alert Response Controller

This block decides when a bus target pulls the shared, open-drain SMBus alert line low, and it answers the host's alert-response query. Each status category supplies a fault-condition level and a mask bit. A condition that is present sets a sticky latch for its category. The alert line is driven whenever any latch is set in a category whose mask bit is clear.

When the host starts a read to the alert response address, the bus target's address decoder hands the received address byte to this block. The block acknowledges only while it is raising the alert. It then shifts its own 7-bit target address out on SDA, most significant bit first, with a zero in bit 0. It follows the usual open-drain arbitration rule: a device that sends a 1 and reads back a 0 has lost. If all eight bits go out without losing arbitration, the block clears its latches and releases the alert line. Categories whose condition is still present re-latch one cycle later. The communication/logic category is the exception: it stays quiet until its condition has gone away and come back, or until a clear.

The bus target keeps the bit-level timing. It gives a `bit_sample` pulse at each SCL rising edge, a `stop` pulse at a STOP condition, and uses `sda_pull` to drive SDA low during data bits.

Top module: `alert_resp_ctrl`

## Requirements
- R1: After reset, `alert_pull`, `sda_pull` and `addr_ack` are all 0.
- R2: A fault condition present at a clock edge sets that category's latch. With the category unmasked, `alert_pull` is 1 from that edge on. It stays 1 after the condition goes away, until a clear or a won alert response.
- R3: A set mask bit keeps its category's latch from driving `alert_pull`, but the latch still sets. Clearing the mask later raises `alert_pull` with no condition present.
- R4: A `clear` pulse loads every latch with its present condition level. `alert_pull` drops unless an unmasked condition is still present.
- R5: The alert response address is 7'b0001100 with R/W bit 1, so the address byte is 8'h19. `addr_ack` is 1 in the same cycle as `addr_valid` with that byte, provided `alert_pull` is 1.
- R6: `addr_ack` stays 0 for byte 8'h19 while `alert_pull` is 0. It also stays 0 for the write form 8'h18 and for any other address.
- R7: After an acknowledged alert response address, the response byte is `{own_addr, 1'b0}`. It is sent MSB first, one bit per `bit_sample` pulse. `sda_pull` is 1 exactly while the current bit is 0.
- R8: If a bit sent as 1 is sampled as 0 on `sda_in`, the block stops driving SDA (`sda_pull` 0) for the rest of the transaction. The latches stay set, so `alert_pull` stays 1.
- R9: When all 8 bits are sent without loss, every latch clears and `alert_pull` is 0 in the following cycle. A non-communication category whose condition is still present re-latches one cycle later.
- R10: After a won response, a still-present condition in the communication category (index `COMM_IDX`, default 3) does not re-latch. It latches again only once the condition has gone low and returns.
- R11: A `stop` pulse ends a response in progress, and `sda_pull` is 0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_cond | input | NCAT | Fault condition level per status category |
| fault_mask | input | NCAT | Per-category mask; 1 keeps the category off the alert line |
| clear | input | 1 | Clear-faults pulse |
| own_addr | input | 7 | Own 7-bit target address |
| addr_valid | input | 1 | Address byte received from the bus (one-cycle pulse) |
| addr_byte | input | 8 | Received address byte, R/W in bit 0 |
| addr_ack | output | 1 | ACK the current address byte |
| bit_sample | input | 1 | SCL rising edge of a data bit (one-cycle pulse) |
| sda_in | input | 1 | SDA level at that edge |
| stop | input | 1 | STOP condition seen (one-cycle pulse) |
| sda_pull | output | 1 | Drive SDA low for the current data bit |
| alert_pull | output | 1 | Drive the alert line low |

## Verification
A latch set wrongly in this block shows at `alert_pull` on the edge after the bad event and stays there, because latches are sticky. A latch cleared wrongly shows as an alert missing on that same edge. A wrong response-shift state shows at `sda_pull` in the very next data bit. A wrong arbitration decision shows as a response that keeps driving after losing, or as an alert released without a win. The release-and-reassert order after a won response plays out over the two cycles after the last bit, and the bench checks `alert_pull` in each of those cycles.

// File: rtl/ara_pkg.sv
package ara_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = ADDR_W + 1;
  localparam logic [ADDR_W-1:0] ARA_ADDR = 7'b0001100;

  typedef enum logic {S_IDLE, S_SEND} resp_state_t;

  // Response data byte: own address in the top bits, zero in bit 0.
  function automatic logic [BYTE_W-1:0] resp_byte(input logic [ADDR_W-1:0] own);
    return {own, 1'b0};
  endfunction

  // Read form of the alert response address.
  function automatic logic ara_match(input logic [BYTE_W-1:0] ab);
    return (ab[BYTE_W-1:1] == ARA_ADDR) && ab[0];
  endfunction

  // Open-drain arbitration: released line (1) read back as 0.
  function automatic logic arb_lost(input logic sent, input logic line);
    return sent && !line;
  endfunction
endpackage

// File: rtl/fault_latch_cell.sv
module fault_latch_cell #(
  parameter bit HOLD_OFF_AFTER_WIN = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  input  logic clear,
  input  logic win,
  output logic latched
);
  logic hold_off;
  logic set_ok;

  generate
    if (HOLD_OFF_AFTER_WIN) begin : g_hold
      always_ff @(posedge clk) begin
        if (!rst_n)     hold_off <= 1'b0;
        else if (win)   hold_off <= cond;
        else if (clear) hold_off <= 1'b0;
        else if (!cond) hold_off <= 1'b0;
      end
    end else begin : g_nohold
      assign hold_off = 1'b0;
    end
  endgenerate

  assign set_ok = cond && !hold_off;

  always_ff @(posedge clk) begin
    if (!rst_n)     latched <= 1'b0;
    else if (win)   latched <= 1'b0;
    else if (clear) latched <= cond;
    else            latched <= latched | set_ok;
  end

  // R2
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latched && !clear && !win |=> latched);
  // R4
  clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear && !win && !cond |=> !latched);
  // R10
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_off && cond && !clear && !win && !latched |=> !latched);
endmodule

// File: rtl/alert_agg.sv
module alert_agg #(
  parameter int NCAT = 4
) (
  input  logic [NCAT-1:0] latched,
  input  logic [NCAT-1:0] mask,
  output logic            alert
);
  logic [NCAT-1:0] live;
  assign live  = latched & ~mask;
  assign alert = |live;
endmodule

// File: rtl/ara_responder.sv
module ara_responder
  import ara_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              alert_active,
  input  logic              addr_valid,
  input  logic [BYTE_W-1:0] addr_byte,
  input  logic              bit_sample,
  input  logic              sda_in,
  input  logic              stop,
  output logic              addr_ack,
  output logic              sda_pull,
  output logic              win,
  output logic              lost
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  resp_state_t       state;
  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic              ara_hit;
  logic              tx_bit;
  logic              sending;

  assign ara_hit  = addr_valid && ara_match(addr_byte);
  assign addr_ack = ara_hit && alert_active;
  assign sending  = (state == S_SEND);
  assign tx_bit   = shreg[BYTE_W-1];
  assign sda_pull = sending && !tx_bit;
  assign lost     = sending && bit_sample && !stop && arb_lost(tx_bit, sda_in);
  assign win      = sending && bit_sample && !stop && !lost && (cnt == LAST_BIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      shreg <= '0;
      cnt   <= '0;
    end else if (stop) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE: if (addr_ack) begin
          state <= S_SEND;
          shreg <= resp_byte(own_addr);
          cnt   <= '0;
        end
        S_SEND: if (bit_sample) begin
          if (lost || win) state <= S_IDLE;
          shreg <= {shreg[BYTE_W-2:0], 1'b0};
          cnt   <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8
  lost_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lost |=> !sda_pull);
  // R5
  ack_alert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ack |-> alert_active);
  // R11
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !sda_pull);
endmodule

// File: rtl/alert_resp_ctrl.sv
module alert_resp_ctrl
  import ara_pkg::*;
#(
  parameter int NCAT     = 4,
  parameter int COMM_IDX = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCAT-1:0]   fault_cond,
  input  logic [NCAT-1:0]   fault_mask,
  input  logic              clear,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              addr_valid,
  input  logic [BYTE_W-1:0] addr_byte,
  output logic              addr_ack,
  input  logic              bit_sample,
  input  logic              sda_in,
  input  logic              stop,
  output logic              sda_pull,
  output logic              alert_pull
);
  logic [NCAT-1:0] latched;
  logic            win;
  logic            lost;

  for (genvar c = 0; c < NCAT; c++) begin : g_cat
    fault_latch_cell #(.HOLD_OFF_AFTER_WIN(c == COMM_IDX)) u_cell (
      .clk(clk), .rst_n(rst_n), .cond(fault_cond[c]), .clear(clear),
      .win(win), .latched(latched[c]));
  end

  alert_agg #(.NCAT(NCAT)) u_agg (
    .latched(latched), .mask(fault_mask), .alert(alert_pull));

  ara_responder u_resp (
    .clk(clk), .rst_n(rst_n), .own_addr(own_addr), .alert_active(alert_pull),
    .addr_valid(addr_valid), .addr_byte(addr_byte), .bit_sample(bit_sample),
    .sda_in(sda_in), .stop(stop), .addr_ack(addr_ack), .sda_pull(sda_pull),
    .win(win), .lost(lost));

  // R9
  win_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win |=> !alert_pull);
  // R8
  lost_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lost && !clear |=> alert_pull);
endmodule

// File: tb/tb_alert_resp_ctrl.sv
module tb_alert_resp_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] fault_cond = '0, fault_mask = '0;
  logic clear = 1'b0, addr_valid = 1'b0, bit_sample = 1'b0, sda_in = 1'b1, stop = 1'b0;
  logic [6:0] own_addr = 7'h5A;
  logic [7:0] addr_byte = '0;
  logic addr_ack, sda_pull, alert_pull;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  alert_resp_ctrl dut (.*);

  // cond, mask, clear, expected alert one cycle later
  localparam logic [9:0] VEC [9] = '{
    {4'b0001, 4'b0000, 1'b0, 1'b1},  // R2 set
    {4'b0000, 4'b0000, 1'b0, 1'b1},  // R2 sticky
    {4'b0000, 4'b0000, 1'b1, 1'b0},  // R4 clear
    {4'b0100, 4'b0100, 1'b0, 1'b0},  // R3 masked
    {4'b0000, 4'b0000, 1'b0, 1'b1},  // R3 unmask shows latch
    {4'b0010, 4'b0000, 1'b1, 1'b1},  // R4 clear, still present
    {4'b0000, 4'b0000, 1'b1, 1'b0},  // R4 clear
    {4'b1000, 4'b0000, 1'b0, 1'b1},  // R2 comm category
    {4'b0000, 4'b0000, 1'b1, 1'b0}   // R4 clear
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic ara(input logic [7:0] a, input logic exp_ack, input string tag);
    @(negedge clk);
    addr_valid = 1'b1; addr_byte = a;
    #1 chk(tag, addr_ack, exp_ack);
    @(negedge clk);
    addr_valid = 1'b0;
  endtask

  // Sends full byte, line follows the device; ends at negedge after last edge.
  task automatic shift_all(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      #1 chk("R7 data bit", sda_pull, ~b[i]);
      bit_sample = 1'b1; sda_in = b[i];
      @(negedge clk);
      bit_sample = 1'b0; sda_in = 1'b1;
    end
  endtask

  task automatic set_cond(input logic [3:0] c, input logic cl);
    @(negedge clk);
    fault_cond = c; clear = cl;
    @(negedge clk);
    clear = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 chk("R1 alert", alert_pull, 1'b0);
    chk("R1 sda", sda_pull, 1'b0);
    chk("R1 ack", addr_ack, 1'b0);
    rst_n = 1'b1;

    foreach (VEC[k]) begin
      @(negedge clk);
      fault_cond = VEC[k][9:6]; fault_mask = VEC[k][5:2]; clear = VEC[k][1];
      @(negedge clk);
      clear = 1'b0;
      #1 chk($sformatf("R2/R3/R4 vector %0d", k), alert_pull, VEC[k][0]);
    end

    // R6: no alert -> NACK
    ara(8'h19, 1'b0, "R6 nack idle");
    // R9: win with persistent non-comm fault
    set_cond(4'b0001, 1'b0);
    ara(8'h18, 1'b0, "R6 write form");
    ara(8'hB5, 1'b0, "R6 other addr");
    ara(8'h19, 1'b1, "R5 ack");
    shift_all(8'hB4);
    #1 chk("R9 released", alert_pull, 1'b0);
    @(negedge clk);
    #1 chk("R9 reasserted", alert_pull, 1'b1);

    // R8: arbitration loss on first bit (a 1)
    ara(8'h19, 1'b1, "R5 ack again");
    #1 chk("R7 first bit", sda_pull, 1'b0);
    bit_sample = 1'b1; sda_in = 1'b0;
    @(negedge clk);
    bit_sample = 1'b0; sda_in = 1'b1;
    #1 chk("R8 stops driving", sda_pull, 1'b0);
    chk("R8 alert kept", alert_pull, 1'b1);
    bit_sample = 1'b1; sda_in = 1'b1;
    @(negedge clk);
    bit_sample = 1'b0;
    #1 chk("R8 stays off", sda_pull, 1'b0);
    chk("R8 alert still kept", alert_pull, 1'b1);

    // R11: stop mid response
    ara(8'h19, 1'b1, "R5 ack third");
    bit_sample = 1'b1; sda_in = 1'b1;
    @(negedge clk);
    bit_sample = 1'b0;
    #1 chk("R7 second bit 0", sda_pull, 1'b1);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    #1 chk("R11 stop releases", sda_pull, 1'b0);
    chk("R11 alert kept", alert_pull, 1'b1);

    // R10: comm category persistent after win
    set_cond(4'b0000, 1'b1);
    #1 chk("R4 cleared", alert_pull, 1'b0);
    set_cond(4'b1000, 1'b0);
    #1 chk("R2 comm set", alert_pull, 1'b1);
    ara(8'h19, 1'b1, "R5 ack comm");
    shift_all(8'hB4);
    #1 chk("R9 comm released", alert_pull, 1'b0);
    @(negedge clk);
    #1 chk("R10 no reassert", alert_pull, 1'b0);
    @(negedge clk);
    #1 chk("R10 still quiet", alert_pull, 1'b0);
    set_cond(4'b0000, 1'b0);
    set_cond(4'b1000, 1'b0);
    #1 chk("R10 returns", alert_pull, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule